// File: doc/BRIEF.md
# Upset-Tolerant Readout Sequencer

A small control state machine that steps a readout through arming, hit collection, serial shifting and a final flush. Its state register never holds the state in plain binary: it stores an 8-bit extended Hamming codeword (four data bits, three check bits and one overall parity bit). This lets the block survive radiation-induced bit flips in that register.

Every cycle the stored codeword is decoded. A single flipped bit is corrected before the next-state logic sees the state, and it is reported on a live flag. When the recovery input is high, the repaired, re-encoded next state is written back on the same edge. A double flip cannot be located. It is reported on a sticky flag and forces the machine back to idle. A mask input XORs any pattern into the stored word, so that tests can model upsets.

Top module: `hamm_guard_fsm`

## Requirements
- R1: While `rst_n` is low, the stored codeword is 8'h00, `state_o` is 0 (IDLE), and `sec_o` and `ded_o` are 0.
- R2: The state codes are IDLE=0, ARM=1, COLLECT=2, SHIFT=3 and FLUSH=4. The transitions are:
  - IDLE goes to ARM on `trig_i`.
  - ARM goes to COLLECT unconditionally.
  - COLLECT goes to SHIFT on `hit_i`, or else to FLUSH on `last_i`. `hit_i` wins when both are high.
  - SHIFT goes to COLLECT on `sdone_i`.
  - FLUSH goes to IDLE on `sdone_i`.
  - In every other case the state holds.
- R3: `code_o` holds the stored codeword. For a state d, bit7=d3, bit6=d2, bit5=d1, bit3=d0, bit1=d0^d1^d3, bit2=d0^d2^d3, bit4=d1^d2^d3, and bit0 is the XOR of bits 7..1. Without injection, a clean codeword stays clean.
- R4: When exactly one bit of the stored codeword is wrong, `sec_o` is 1 and `state_o` shows the corrected state.
- R5: With `recover_en` high and a single error present, the next edge loads the encoding of the next state, which is computed from the corrected state. This clears `sec_o`, including in a state that holds.
- R6: With `recover_en` low, a single error stays stored, and `sec_o` stays 1, until a state change rewrites the codeword. Transitions still follow the corrected state.
- R7: A double error gives `sec_o`=0 and `state_o`=0. On the next edge the register loads the IDLE codeword and `ded_o` is set. `ded_o` then stays 1 until reset.
- R8: A non-zero `flip_mask` XORs into the stored codeword on the edge. Event inputs are ignored on that edge.
- R9: A correctly coded but undefined state (5..15) goes to IDLE on the next edge, whatever the event inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| recover_en | input | 1 | Enables write-back after a single-bit error |
| trig_i | input | 1 | Start a readout |
| hit_i | input | 1 | Hit data available |
| last_i | input | 1 | Last hit of the frame |
| sdone_i | input | 1 | Serial shift finished |
| flip_mask | input | 8 | Test hook XORed into the stored codeword |
| state_o | output | 4 | Decoded (corrected) state |
| code_o | output | 8 | Stored codeword |
| sec_o | output | 1 | Single-bit error present in the stored word |
| ded_o | output | 1 | Sticky double-bit error flag |

## Verification
Two functions collide when an upset and a state transition fall in the same cycle. The first collision is a corrected single error that meets an event which moves the machine. The second is a double error that meets an event which would otherwise be taken. The bench provokes the first by flipping one bit while in COLLECT and raising `hit_i` on the following cycle. It judges the result by checking that the codeword loaded is exactly the clean encoding of SHIFT and that `sec_o` drops. For the double error, it checks that the event is discarded: the codeword becomes 8'h00, and `ded_o` rises and stays high through later transitions.

// File: rtl/hamm_guard_fsm.sv
module hamm_guard_fsm #(
  parameter int SW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          recover_en,
  input  logic          trig_i,
  input  logic          hit_i,
  input  logic          last_i,
  input  logic          sdone_i,
  input  logic [CW-1:0] flip_mask,
  output logic [SW-1:0] state_o,
  output logic [CW-1:0] code_o,
  output logic          sec_o,
  output logic          ded_o
);
  localparam logic [SW-1:0] S_IDLE    = 4'd0;
  localparam logic [SW-1:0] S_ARM     = 4'd1;
  localparam logic [SW-1:0] S_COLLECT = 4'd2;
  localparam logic [SW-1:0] S_SHIFT   = 4'd3;
  localparam logic [SW-1:0] S_FLUSH   = 4'd4;

  function automatic logic [CW-1:0] enc(input logic [SW-1:0] d);
    logic [CW-1:0] w;
    w[7] = d[3];
    w[6] = d[2];
    w[5] = d[1];
    w[3] = d[0];
    w[1] = d[0] ^ d[1] ^ d[3];
    w[2] = d[0] ^ d[2] ^ d[3];
    w[4] = d[1] ^ d[2] ^ d[3];
    w[0] = ^w[7:1];
    return w;
  endfunction

  logic [CW-1:0] word_q, word_d, fixed;
  logic [2:0]    syn;
  logic          par_err, sgl, dbl, ded_q, injecting;
  logic [SW-1:0] cur, nxt;

  assign syn     = {^(word_q & 8'hF0), ^(word_q & 8'hCC), ^(word_q & 8'hAA)};
  assign par_err = ^word_q;
  assign sgl     = par_err;
  assign dbl     = !par_err && (syn != 3'd0);
  assign fixed   = sgl ? (word_q ^ (8'd1 << syn)) : word_q;
  assign cur     = dbl ? S_IDLE : {fixed[7], fixed[6], fixed[5], fixed[3]};
  assign injecting = |flip_mask;

  always_comb begin
    nxt = cur;
    case (cur)
      S_IDLE:    if (trig_i) nxt = S_ARM;
      S_ARM:     nxt = S_COLLECT;
      S_COLLECT: if (hit_i) nxt = S_SHIFT;
                 else if (last_i) nxt = S_FLUSH;
      S_SHIFT:   if (sdone_i) nxt = S_COLLECT;
      S_FLUSH:   if (sdone_i) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_comb begin
    word_d = word_q;
    if (injecting)                              word_d = word_q ^ flip_mask;
    else if (dbl)                               word_d = enc(S_IDLE);
    else if ((nxt != cur) || (sgl && recover_en)) word_d = enc(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ded_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      ded_q  <= ded_q | dbl;
    end
  end

  assign state_o = cur;
  assign code_o  = word_q;
  assign sec_o   = sgl;
  assign ded_o   = ded_q;
endmodule

module hamm_guard_fsm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       recover_en,
  input logic [7:0] flip_mask,
  input logic [7:0] code_o,
  input logic       sec_o,
  input logic       ded_o,
  input logic       dbl
);
  AST_DED_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ded_o |=> ded_o); // R7
  AST_DBL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl && flip_mask == 8'd0) |=> (code_o == 8'd0 && ded_o)); // R7
  AST_SGL_REPAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o && recover_en && flip_mask == 8'd0) |=> !sec_o); // R5
  AST_MASK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_mask != 8'd0) |=> (code_o == ($past(code_o) ^ $past(flip_mask)))); // R8
  AST_CLEAN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_o && !dbl && flip_mask == 8'd0) |=> !sec_o && !dbl); // R3
endmodule

bind hamm_guard_fsm hamm_guard_fsm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .recover_en(recover_en), .flip_mask(flip_mask),
  .code_o(code_o), .sec_o(sec_o), .ded_o(ded_o), .dbl(dbl)
);

// File: tb/test_hamm_guard_fsm.sv
module test_hamm_guard_fsm;
  logic clk = 1'b0, rst_n = 1'b0, recover_en = 1'b1;
  logic trig_i = 0, hit_i = 0, last_i = 0, sdone_i = 0;
  logic [7:0] flip_mask = '0;
  logic [3:0] state_o;
  logic [7:0] code_o;
  logic sec_o, ded_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hamm_guard_fsm i_hamm_guard_fsm (
    .clk(clk), .rst_n(rst_n), .recover_en(recover_en), .trig_i(trig_i),
    .hit_i(hit_i), .last_i(last_i), .sdone_i(sdone_i), .flip_mask(flip_mask),
    .state_o(state_o), .code_o(code_o), .sec_o(sec_o), .ded_o(ded_o)
  );

  typedef struct {
    logic [3:0] st;
    logic [7:0] cw;
    logic sec;
    logic ded;
    string tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [7:0] enc(input logic [3:0] d);
    logic [7:0] w;
    w[7] = d[3]; w[6] = d[2]; w[5] = d[1]; w[3] = d[0];
    w[1] = d[0] ^ d[1] ^ d[3];
    w[2] = d[0] ^ d[2] ^ d[3];
    w[4] = d[1] ^ d[2] ^ d[3];
    w[0] = ^w[7:1];
    return w;
  endfunction

  task automatic compare(input exp_t e);
    checks++;
    if (state_o !== e.st || code_o !== e.cw || sec_o !== e.sec || ded_o !== e.ded) begin
      failures++;
      $display("FAIL %s: got st=%0d cw=%02h sec=%0b ded=%0b, exp st=%0d cw=%02h sec=%0b ded=%0b",
               e.tag, state_o, code_o, sec_o, ded_o, e.st, e.cw, e.sec, e.ded);
    end
  endtask

  task automatic step(input logic t, h, l, s, rec, input logic [7:0] m,
                      input logic [3:0] st, input logic [7:0] cw,
                      input logic sec, ded, input string tag);
    exp_t e;
    @(posedge clk); #1;
    trig_i = t; hit_i = h; last_i = l; sdone_i = s; recover_en = rec; flip_mask = m;
    e.st = st; e.cw = cw; e.sec = sec; e.ded = ded; e.tag = tag;
    sb.push_back(e);
  endtask

  always begin
    int n;
    @(posedge clk);
    n = sb.size();
    #3;
    for (int i = 0; i < n; i++) compare(sb.pop_front());
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    #1;
    e.st = 0; e.cw = 8'h00; e.sec = 0; e.ded = 0; e.tag = "R1 reset";
    compare(e);
    rst_n = 1'b1;
    step(1,0,0,0,1,0, 1, enc(1), 0,0, "R2 idle->arm");
    step(0,0,0,0,1,0, 2, enc(2), 0,0, "R2 arm->collect");
    step(0,1,0,0,1,0, 3, enc(3), 0,0, "R2 collect->shift");
    step(0,0,0,1,1,0, 2, enc(2), 0,0, "R2 shift->collect");
    step(0,1,1,0,1,0, 3, enc(3), 0,0, "R2 hit priority");
    step(0,0,0,1,1,0, 2, enc(2), 0,0, "R2 shift->collect");
    step(0,0,1,0,1,0, 4, enc(4), 0,0, "R2 collect->flush");
    step(0,0,0,0,1,0, 4, enc(4), 0,0, "R2 flush hold");
    step(0,0,0,1,1,0, 0, enc(0), 0,0, "R2 flush->idle");
    step(0,1,1,1,1,0, 0, enc(0), 0,0, "R2 idle hold");
    step(1,0,0,0,1,0, 1, enc(1), 0,0, "R3 arm code");
    step(0,0,0,0,1,0, 2, enc(2), 0,0, "R3 collect code");
    step(0,0,0,0,1,8'h10, 2, enc(2)^8'h10, 1,0, "R4 single corrected");
    step(0,1,0,0,1,0, 3, enc(3), 0,0, "R5 repair with transition");
    step(0,0,0,0,0,8'h01, 3, enc(3)^8'h01, 1,0, "R4 parity bit flip");
    step(0,0,0,0,0,0, 3, enc(3)^8'h01, 1,0, "R6 no repair");
    step(0,0,0,0,0,0, 3, enc(3)^8'h01, 1,0, "R6 flag held");
    step(0,0,0,1,0,0, 2, enc(2), 0,0, "R6 transition rewrites");
    step(0,1,0,0,1,8'h04, 2, enc(2)^8'h04, 1,0, "R8 events ignored on inject");
    step(0,0,0,0,1,0, 2, enc(2), 0,0, "R5 repair in hold");
    step(0,0,0,0,1,8'h06, 0, enc(2)^8'h06, 0,0, "R7 double seen");
    step(0,1,0,0,1,0, 0, enc(0), 0,1, "R7 forced idle");
    step(1,0,0,0,1,0, 1, enc(1), 0,1, "R7 sticky");
    step(0,0,0,0,1,0, 2, enc(2), 0,1, "R7 sticky");
    step(0,0,1,0,1,0, 4, enc(4), 0,1, "R2 flush");
    step(0,0,0,1,1,0, 0, enc(0), 0,1, "R2 idle");
    step(0,0,0,0,1,enc(7), 7, enc(7), 0,1, "R8 arbitrary mask");
    step(1,0,0,0,1,0, 0, enc(0), 0,1, "R9 undefined to idle");
    step(0,0,0,0,1,enc(5)^enc(0), 5, enc(5), 0,1, "R8 mask to 5");
    step(0,1,1,1,1,0, 0, enc(0), 0,1, "R9 undefined 5");
    @(posedge clk); #1;
    @(posedge clk); #4;
    rst_n = 1'b0;
    #1;
    e.st = 0; e.cw = 8'h00; e.sec = 0; e.ded = 0; e.tag = "R1 R7 reset clears";
    compare(e);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule